// File: doc/BRIEF.md
# Pixel Hit Time Capture Cell

This block lives inside one pixel and turns a synchronous discriminator signal into a single time-stamped packet per hit. When a hit starts, the block copies the value of a free-running bunch-crossing counter into a local arrival-time register. That counter is shared and supplied from outside the pixel. A separate duration counter then measures how many cycles the discriminator stays high. When the hit ends, a one-cycle packet carrying both values is presented.

A small control state machine (idle, counting, emitting) produces the capture strobe for the arrival-time register and the clear and enable controls for the duration counter. A per-pixel mask bit, written through a one-bit configuration port, silences the pixel completely. A mask change is applied only while the cell is idle, so a hit that is already being measured always completes. A hit whose rising edge falls in the emitting cycle is not dropped: it starts on the following cycle if the input is still high.

Top module: `pixel_hit_stamp`

## Requirements
- R1: After synchronous active-low reset, `pkt_valid_o` is 0, the effective mask is 0 (pixel enabled) and the cell waits for a rising edge.
- R2: On the clock edge where the sampled hit input rises (1 now, 0 on the previous edge) in the idle state with the mask clear, `bx_count_i` sampled at that edge becomes the packet's arrival time.
- R3: The duration field equals the number of consecutive clock edges at which the hit input was sampled high, counting the onset edge, so it is never 0 in a packet.
- R4: The duration counter saturates at 2^TOT_W-1 (15 with defaults) rather than wrapping.
- R5: `pkt_valid_o` is high for exactly one cycle, the cycle directly after the first edge that samples the hit input low. During that cycle `pkt_toa_o` and `pkt_tot_o` hold the packet.
- R6: With the effective mask at 1, a hit produces no packet at all.
- R7: A mask write is applied only while the cell is idle. Writing 1 during an active hit does not suppress that hit's packet, and writing 1 in idle suppresses hits whose onset edge comes at least one edge after the write edge.
- R8: A rising edge sampled during the emit cycle is held pending. If the input is still high at the next edge, the cell starts there: the arrival time is `bx_count_i` at that later edge and the duration counts from that edge. The input sample taken during the emit cycle is therefore not counted. A pending rising edge whose input has already dropped is discarded.
- R9: A hit that is already high when the mask is cleared produces no packet. Only a new rising edge starts a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, bunch-crossing rate |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_i | input | 1 | Discriminator output, already synchronous to clk |
| bx_count_i | input | TS_W | Shared free-running bunch-crossing count |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_mask_i | input | 1 | Mask value; 1 disables the pixel |
| pkt_valid_o | output | 1 | One-cycle packet valid |
| pkt_toa_o | output | TS_W | Packet arrival time |
| pkt_tot_o | output | TOT_W | Packet duration in cycles |

## Verification
Two functions can fall in the same cycle. One is emitting a finished packet. The other is detecting the rising edge of the next hit, which the bench provokes by raising the input in the exact cycle where `pkt_valid_o` is high. The bench checks that the first packet is intact. It then checks that the second packet carries the crossing count from one edge later and a duration one short of the high samples, or that no second packet appears when the input drops immediately. A mask write landing in the middle of a measurement is a second overlap, and it is judged by the packet still arriving.

// File: rtl/pxs_pkg.sv
// Package: shared types for the pixel hit time capture cell.
// Assumes: nothing beyond IEEE 1800-2017.
package pxs_pkg;

    // Control state machine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_EMIT  = 2'd2
    } pxs_state_e;

    // Control bundle from the state machine to the datapath
    typedef struct packed {
        logic cap;   // copy crossing count into arrival-time register
        logic clr;   // restart duration counter
        logic en;    // advance duration counter
        logic emit;  // packet valid
    } pxs_ctrl_t;

endpackage

// File: rtl/pxs_edge_det.sv
// Module: pxs_edge_det
// Registers the synchronous hit input and flags rising and falling edges
// of it against the previous sample.
// Assumes: hit_i is already synchronous to clk.
module pxs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic hit_q_o,
    output logic rise_o,
    output logic fall_o
);

    logic hit_q;

    // Keep the previous sample of the hit input
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_i;
    end

    // Edge flags against the previous sample
    always_comb begin
        rise_o  = hit_i & ~hit_q;
        fall_o  = ~hit_i & hit_q;
        hit_q_o = hit_q;
    end

endmodule

// File: rtl/pxs_mask_cfg.sv
// Module: pxs_mask_cfg
// Holds the pixel mask bit. Writes land in a shadow register at once, but
// the effective mask follows the shadow only while the cell is idle and is
// frozen otherwise.
// Assumes: idle_i comes from a registered state.
module pxs_mask_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wdata_i,
    input  logic idle_i,
    output logic mask_o
);

    logic shadow_q;
    logic held_q;

    // Shadow register: takes every write
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= 1'b0;
        else if (we_i) shadow_q <= wdata_i;
    end

    // Effective mask: follows the shadow in idle, else the frozen copy
    always_comb begin
        mask_o = idle_i ? shadow_q : held_q;
    end

    // Frozen copy of the effective mask
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= mask_o;
    end

    // R7
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && $past(!idle_i)) |-> $stable(mask_o));

endmodule

// File: rtl/pxs_tot_ctr.sv
// Module: pxs_tot_ctr
// Duration counter. A clear restarts it (at 1 when enable is also high,
// so the onset sample counts). Enable advances it, saturating at all ones.
// Assumes: clear and enable come from the control state machine.
module pxs_tot_ctr #(
    parameter int TOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [TOT_W-1:0] cnt_o
);

    localparam logic [TOT_W-1:0] TOT_MAX = '1;
    localparam logic [TOT_W-1:0] TOT_ONE = TOT_W'(1);

    logic [TOT_W-1:0] cnt_q;

    // Restart, advance or hold the count
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clr_i)                      cnt_q <= en_i ? TOT_ONE : '0;
        else if (en_i && cnt_q != TOT_MAX)   cnt_q <= cnt_q + TOT_ONE;
    end

    assign cnt_o = cnt_q;

    // R4
    tot_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOT_MAX && !clr_i) |=> cnt_q == TOT_MAX);

endmodule

// File: rtl/pxs_toa_reg.sv
// Module: pxs_toa_reg
// Arrival-time register: copies the shared crossing count on the capture
// strobe and holds it otherwise.
// Assumes: bx_i is a free-running count synchronous to clk.
module pxs_toa_reg #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic [TS_W-1:0] bx_i,
    output logic [TS_W-1:0] toa_o
);

    logic [TS_W-1:0] toa_q;

    // Copy the crossing count on capture
    always_ff @(posedge clk) begin
        if (!rst_n)     toa_q <= '0;
        else if (cap_i) toa_q <= bx_i;
    end

    assign toa_o = toa_q;

endmodule

// File: rtl/pxs_ctrl_fsm.sv
// Module: pxs_ctrl_fsm
// Control state machine: idle -> count on a rising edge with the mask clear,
// count -> emit when the input drops, emit -> idle after one cycle. A rising
// edge seen while emitting is kept pending for one cycle.
// Assumes: mask_i is the effective (idle-gated) mask.
module pxs_ctrl_fsm
    import pxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic       rise_i,
    input  logic       mask_i,
    output pxs_ctrl_t  ctrl_o,
    output pxs_state_e state_o
);

    pxs_state_e state_q, state_d;
    logic       pend_q;
    logic       start;

    // Start a measurement from idle
    always_comb begin
        start = (state_q == ST_IDLE) && !mask_i && hit_i && (rise_i || pend_q);
    end

    // Next state and control outputs
    always_comb begin
        state_d = state_q;
        ctrl_o  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctrl_o.cap = 1'b1;
                    ctrl_o.clr = 1'b1;
                    ctrl_o.en  = 1'b1;
                    state_d    = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (hit_i) ctrl_o.en = 1'b1;
                else       state_d   = ST_EMIT;
            end
            ST_EMIT: begin
                ctrl_o.emit = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pending rising edge seen during the emit cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (state_q == ST_EMIT) && rise_i;
    end

    assign state_o = state_q;

    // R6
    masked_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mask_i) |=> state_q == ST_IDLE);

    // R8
    emit_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |=> state_q == ST_IDLE);

endmodule

// File: rtl/pixel_hit_stamp.sv
// Module: pixel_hit_stamp (top)
// Per-pixel hit time capture: arrival time copied from the shared crossing
// count at onset, duration counted while high, one-cycle packet at hit end.
// Mask bit gated into effect only while idle.
// Assumes: hit_i and bx_count_i are synchronous to clk.
module pixel_hit_stamp
    import pxs_pkg::*;
#(
    parameter int TS_W  = 8,
    parameter int TOT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [TS_W-1:0]  bx_count_i,
    input  logic             cfg_we_i,
    input  logic             cfg_mask_i,
    output logic             pkt_valid_o,
    output logic [TS_W-1:0]  pkt_toa_o,
    output logic [TOT_W-1:0] pkt_tot_o
);

    logic       hit_q, rise, fall;
    logic       mask_eff;
    pxs_ctrl_t  ctrl;
    pxs_state_e state;

    pxs_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit_i),
        .hit_q_o (hit_q),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    pxs_mask_cfg u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_mask_i),
        .idle_i  (state == ST_IDLE),
        .mask_o  (mask_eff)
    );

    pxs_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit_i),
        .rise_i  (rise),
        .mask_i  (mask_eff),
        .ctrl_o  (ctrl),
        .state_o (state)
    );

    pxs_toa_reg #(.TS_W(TS_W)) u_toa (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (ctrl.cap),
        .bx_i  (bx_count_i),
        .toa_o (pkt_toa_o)
    );

    pxs_tot_ctr #(.TOT_W(TOT_W)) u_tot (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ctrl.clr),
        .en_i  (ctrl.en),
        .cnt_o (pkt_tot_o)
    );

    assign pkt_valid_o = ctrl.emit;

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |=> !pkt_valid_o);

    // R5
    valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && fall) |=> pkt_valid_o);

    // R3
    count_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> hit_q);

    // R3
    tot_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> pkt_tot_o != '0);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !pkt_valid_o);

endmodule

// File: tb/pixel_hit_stamp_tb_top.sv
// Bench: sweeps hit lengths, mask timings and back-to-back hits on the
// default configuration, with expected fields computed arithmetically.
module pixel_hit_stamp_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TS_W       = 8;
    localparam int TOT_W      = 4;
    localparam int TOT_MAX    = (1 << TOT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hit_i = 1'b0;
    logic [TS_W-1:0]  bx_count_i = '0;
    logic             cfg_we_i = 1'b0;
    logic             cfg_mask_i = 1'b0;
    logic             pkt_valid_o;
    logic [TS_W-1:0]  pkt_toa_o;
    logic [TOT_W-1:0] pkt_tot_o;

    int n_vec  = 0;
    int n_fail = 0;
    int pkt_cnt = 0;
    bit done = 1'b0;

    pixel_hit_stamp #(.TS_W(TS_W), .TOT_W(TOT_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit_i),
        .bx_count_i  (bx_count_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_mask_i  (cfg_mask_i),
        .pkt_valid_o (pkt_valid_o),
        .pkt_toa_o   (pkt_toa_o),
        .pkt_tot_o   (pkt_tot_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running crossing count, changed just after each rising edge
    always begin
        @(posedge clk);
        #1;
        bx_count_i = bx_count_i + 8'd1;
    end

    // Count every valid packet cycle
    always @(negedge clk) if (rst_n && pkt_valid_o) pkt_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    task automatic cfg_write(input bit v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_mask_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    // One hit of n high samples; checks packet presence and fields
    task automatic pulse(input int n, input bit exp_pkt, input string req);
        logic [TS_W-1:0] e_toa;
        int e_tot;
        e_tot = (n > TOT_MAX) ? TOT_MAX : n;
        pkt_cnt = 0;
        @(negedge clk); hit_i = 1'b1; e_toa = bx_count_i;
        repeat (n - 1) @(negedge clk);
        @(negedge clk); hit_i = 1'b0;
        @(negedge clk);
        chk(req, int'(pkt_valid_o), int'(exp_pkt));
        if (exp_pkt) begin
            chk(req, int'(pkt_toa_o), int'(e_toa));
            chk(req, int'(pkt_tot_o), e_tot);
        end
        @(negedge clk);
        chk(req, int'(pkt_valid_o), 0);
        @(negedge clk);
        chk(req, pkt_cnt, int'(exp_pkt));
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [TS_W-1:0] t1, t2;
        int k_high;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", int'(pkt_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(pkt_valid_o), 0);
        // R1: mask is 0 after reset, so a hit is processed
        pulse(2, 1'b1, "R1");

        // R2 R3 R4 R5: sweep of hit lengths across saturation
        for (int n = 1; n <= 20; n++) begin
            pulse(n, 1'b1, (n > TOT_MAX) ? "R4" : "R3");
            for (int g = 0; g < (n % 3); g++) @(negedge clk);
        end

        // R6: masked pixel produces nothing
        cfg_write(1'b1);
        for (int n = 1; n <= 5; n++) pulse(n, 1'b0, "R6");
        cfg_write(1'b0);
        pulse(3, 1'b1, "R6");

        // R7: mask written mid-hit does not stop the current packet
        pkt_cnt = 0;
        @(negedge clk); hit_i = 1'b1; t1 = bx_count_i;
        @(negedge clk); cfg_we_i = 1'b1; cfg_mask_i = 1'b1;
        @(negedge clk); cfg_we_i = 1'b0;
        @(negedge clk); hit_i = 1'b0;
        @(negedge clk);
        chk("R7", int'(pkt_valid_o), 1);
        chk("R7", int'(pkt_toa_o), int'(t1));
        chk("R7", int'(pkt_tot_o), 3);
        @(negedge clk);
        pulse(3, 1'b0, "R7");
        // R7: onset one edge after an idle write is already masked
        cfg_write(1'b0);
        pkt_cnt = 0;
        @(negedge clk); cfg_we_i = 1'b1; cfg_mask_i = 1'b1;
        @(negedge clk); cfg_we_i = 1'b0; hit_i = 1'b1;
        repeat (2) @(negedge clk);
        hit_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", pkt_cnt, 0);

        // R9: input high when unmasked does not start a measurement
        pkt_cnt = 0;
        @(negedge clk); hit_i = 1'b1;
        cfg_write(1'b0);
        repeat (3) @(negedge clk);
        hit_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", pkt_cnt, 0);
        pulse(4, 1'b1, "R9");

        // R8: rising edge in the emit cycle, held for k samples
        for (int k = 1; k <= 6; k++) begin
            pkt_cnt = 0;
            @(negedge clk); hit_i = 1'b1; t1 = bx_count_i;
            @(negedge clk);
            @(negedge clk); hit_i = 1'b0;
            @(negedge clk);
            chk("R8", int'(pkt_valid_o), 1);
            chk("R8", int'(pkt_toa_o), int'(t1));
            chk("R8", int'(pkt_tot_o), 2);
            hit_i = 1'b1;
            t2 = bx_count_i + 8'd1;
            k_high = k;
            repeat (k_high - 1) @(negedge clk);
            @(negedge clk); hit_i = 1'b0;
            @(negedge clk);
            if (k_high >= 2) begin
                chk("R8", int'(pkt_valid_o), 1);
                chk("R8", int'(pkt_toa_o), int'(t2));
                chk("R8", int'(pkt_tot_o), k_high - 1);
            end
            repeat (2) @(negedge clk);
            chk("R8", pkt_cnt, (k_high >= 2) ? 2 : 1);
        end

        finish_run();
    end

endmodule